// File: doc/BRIEF.md
# Auto-Initializing DMA Address/Count Engine

This block holds the per-channel transfer state of a four-channel DMA controller. Each channel keeps a 16-bit current address, a 16-bit current count, and a base copy of both. A programming write to a channel's address or count loads the base and current copies in the same cycle. A per-channel mode write chooses the address direction and turns auto-initialization on or off.

The surrounding controller signals one transfer at a time by raising `xfer` with the channel number. In that same cycle the engine shows the channel's current address on `xfer_addr`. On the next edge the engine steps the address by one and decrements the count. The count is programmed as N-1, so a channel performs N transfers. The transfer that finds the count at zero is the last one. During that transfer the engine raises `eop`, and on the following edge it sets the channel's terminal-count status bit. At that point an auto-initializing channel copies its base pair back into the current pair. Any other channel sets its request mask bit, so further transfers for it are ignored until the mask is cleared.

A readback port shows the four registers of any channel. Register decode and bus strobes on the processor side belong to other blocks.

Top module: `dma_ac_engine`

## Requirements
- R1: After reset, every address and count register is 0, every request mask bit is 1, every status bit is 0, every channel increments its address, and auto-initialization is off.
- R2: A write with `prog_sel`=0 loads the channel's base and current address from `prog_data`. A write with `prog_sel`=1 loads its base and current count. Both take effect on the next edge.
- R3: `xfer_addr` always equals the current address of the channel selected by `xfer_ch`, in the same cycle.
- R4: A transfer is accepted when `xfer` is high and the channel's mask bit is 0. An accepted transfer adds one to the current address (mode_down=0) or subtracts one (mode_down=1), modulo 2^16.
- R5: Each accepted transfer decrements the current count by one, modulo 2^16. A count programmed as N-1 therefore gives N transfers.
- R6: `eop` is high, in the same cycle, exactly when an accepted transfer finds its channel's current count at 0. Without auto-initialization the count then becomes 0xFFFF.
- R7: A terminal transfer sets that channel's `tc_status` bit on the next edge. `status_rd` clears all status bits on the next edge. A terminal transfer in the same cycle as `status_rd` leaves its bit set.
- R8: On a terminal transfer with auto-initialization on, the current address and count are reloaded from the base pair. Transfers never change the base registers.
- R9: On a terminal transfer without auto-initialization, the channel's `req_mask` bit is set. With auto-initialization it is not set. Bit i of `mask_clr` clears mask bit i, and a set in the same cycle wins.
- R10: A transfer for a masked channel has no effect: the address, count and status are unchanged, and `eop` stays low.
- R11: If a programming write and a transfer target the same channel in the same cycle, the write takes effect and the transfer is ignored.
- R12: Transfers, writes and terminal events on one channel leave the registers, status and mask of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Programming write strobe |
| prog_ch | input | 2 | Channel for the programming write |
| prog_sel | input | 1 | 0 = address, 1 = count |
| prog_data | input | 16 | Value written |
| mode_we | input | 1 | Mode write strobe |
| mode_ch | input | 2 | Channel for the mode write |
| mode_autoinit | input | 1 | Auto-initialization enable |
| mode_down | input | 1 | 1 = decrement the address, 0 = increment it |
| xfer | input | 1 | Transfer pulse |
| xfer_ch | input | 2 | Channel performing the transfer |
| xfer_addr | output | 16 | Current address of `xfer_ch` |
| eop | output | 1 | End of process, high during the terminal transfer |
| status_rd | input | 1 | Status read, clears the status bits |
| tc_status | output | 4 | Per-channel terminal-count status |
| mask_clr | input | 4 | Per-channel request mask clear |
| req_mask | output | 4 | Per-channel request mask |
| rd_ch | input | 2 | Channel shown on the readback port |
| rd_cur_addr | output | 16 | Current address of `rd_ch` |
| rd_cur_cnt | output | 16 | Current count of `rd_ch` |
| rd_base_addr | output | 16 | Base address of `rd_ch` |
| rd_base_cnt | output | 16 | Base count of `rd_ch` |

## Verification
A wrong address or count step appears on `xfer_addr` at the channel's next transfer. It also appears on the readback port one cycle after the faulty edge. A count error moves the terminal transfer, so `eop`, the status bit and the mask bit change in the wrong cycle. A failed reload or a corrupted base register shows up once the next run of an auto-initializing channel begins. The bench rotates the readback channel every cycle, so any wrong register is visible within four cycles.

// File: rtl/dma_ac_pkg.sv
package dma_ac_pkg;
    typedef enum logic {
        PROG_ADDR = 1'b0,
        PROG_CNT  = 1'b1
    } prog_sel_e;
endpackage

// File: rtl/dma_chan_state.sv
module dma_chan_state #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we_i,
    input  logic              cnt_we_i,
    input  logic [ADDR_W-1:0] addr_data_i,
    input  logic [CNT_W-1:0]  cnt_data_i,
    input  logic              mode_we_i,
    input  logic              autoinit_i,
    input  logic              down_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  cur_cnt_o,
    output logic [ADDR_W-1:0] base_addr_o,
    output logic [CNT_W-1:0]  base_cnt_o,
    output logic              autoinit_o,
    output logic              tc_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base_addr;
        logic [ADDR_W-1:0] cur_addr;
        logic [CNT_W-1:0]  base_cnt;
        logic [CNT_W-1:0]  cur_cnt;
        logic              autoinit;
        logic              down;
    } chan_t;

    chan_t chan_d, chan_q;
    logic  last_xfer;
    logic [ADDR_W-1:0] addr_stepped;

    always_comb begin
        last_xfer    = step_i && (chan_q.cur_cnt == '0);
        addr_stepped = chan_q.down ? chan_q.cur_addr - 1'b1
                                   : chan_q.cur_addr + 1'b1;
        chan_d = chan_q;
        if (step_i) begin
            if (last_xfer && chan_q.autoinit) begin
                chan_d.cur_addr = chan_q.base_addr;
                chan_d.cur_cnt  = chan_q.base_cnt;
            end else begin
                chan_d.cur_addr = addr_stepped;
                chan_d.cur_cnt  = chan_q.cur_cnt - 1'b1;
            end
        end
        if (mode_we_i) begin
            chan_d.autoinit = autoinit_i;
            chan_d.down     = down_i;
        end
        if (addr_we_i) begin
            chan_d.base_addr = addr_data_i;
            chan_d.cur_addr  = addr_data_i;
        end
        if (cnt_we_i) begin
            chan_d.base_cnt = cnt_data_i;
            chan_d.cur_cnt  = cnt_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign cur_addr_o  = chan_q.cur_addr;
    assign cur_cnt_o   = chan_q.cur_cnt;
    assign base_addr_o = chan_q.base_addr;
    assign base_cnt_o  = chan_q.base_cnt;
    assign autoinit_o  = chan_q.autoinit;
    assign tc_o        = last_xfer;

    // R5
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !addr_we_i && !cnt_we_i && cur_cnt_o != '0)
        |=> cur_cnt_o == $past(cur_cnt_o) - 1'b1);

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && autoinit_o && !addr_we_i && !cnt_we_i)
        |=> (cur_addr_o == base_addr_o) && (cur_cnt_o == base_cnt_o));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !addr_we_i && !cnt_we_i)
        |=> $stable(cur_addr_o) && $stable(cur_cnt_o) && $stable(base_addr_o));
endmodule

// File: rtl/dma_tc_track.sv
module dma_tc_track #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_i,
    input  logic [NUM_CH-1:0] autoinit_i,
    input  logic              status_rd_i,
    input  logic [NUM_CH-1:0] mask_clr_i,
    output logic [NUM_CH-1:0] tc_status_o,
    output logic [NUM_CH-1:0] mask_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] mask;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.tc   = (status_rd_i ? '0 : trk_q.tc) | tc_i;
        trk_d.mask = (trk_q.mask & ~mask_clr_i) | (tc_i & ~autoinit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{tc: '0, mask: '1};
        else        trk_q <= trk_d;
    end

    assign tc_status_o = trk_q.tc;
    assign mask_o      = trk_q.mask;

    // R7
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i != '0) |=> ((tc_status_o & $past(tc_i)) == $past(tc_i)));

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tc_i & ~autoinit_i) != '0)
        |=> ((mask_o & $past(tc_i & ~autoinit_i)) == $past(tc_i & ~autoinit_i)));
endmodule

// File: rtl/dma_ac_engine.sv
module dma_ac_engine #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned DATA_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [CH_W-1:0]   prog_ch,
    input  logic              prog_sel,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              mode_we,
    input  logic [CH_W-1:0]   mode_ch,
    input  logic              mode_autoinit,
    input  logic              mode_down,
    input  logic              xfer,
    input  logic [CH_W-1:0]   xfer_ch,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              eop,
    input  logic              status_rd,
    output logic [NUM_CH-1:0] tc_status,
    input  logic [NUM_CH-1:0] mask_clr,
    output logic [NUM_CH-1:0] req_mask,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [ADDR_W-1:0] rd_cur_addr,
    output logic [CNT_W-1:0]  rd_cur_cnt,
    output logic [ADDR_W-1:0] rd_base_addr,
    output logic [CNT_W-1:0]  rd_base_cnt
);
    import dma_ac_pkg::*;

    logic [ADDR_W-1:0] cur_addr_a  [NUM_CH];
    logic [CNT_W-1:0]  cur_cnt_a   [NUM_CH];
    logic [ADDR_W-1:0] base_addr_a [NUM_CH];
    logic [CNT_W-1:0]  base_cnt_a  [NUM_CH];
    logic [NUM_CH-1:0] tc_vec;
    logic [NUM_CH-1:0] auto_vec;
    logic              xfer_ok;
    prog_sel_e         sel;

    assign sel     = prog_sel_e'(prog_sel);
    assign xfer_ok = xfer && !req_mask[xfer_ch] && !(prog_we && (prog_ch == xfer_ch));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic chan_sel_prog;
        assign chan_sel_prog = prog_we && (prog_ch == CH_W'(g));

        dma_chan_state #(
            .ADDR_W(ADDR_W),
            .CNT_W (CNT_W)
        ) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr_we_i  (chan_sel_prog && (sel == PROG_ADDR)),
            .cnt_we_i   (chan_sel_prog && (sel == PROG_CNT)),
            .addr_data_i(prog_data[ADDR_W-1:0]),
            .cnt_data_i (prog_data[CNT_W-1:0]),
            .mode_we_i  (mode_we && (mode_ch == CH_W'(g))),
            .autoinit_i (mode_autoinit),
            .down_i     (mode_down),
            .step_i     (xfer_ok && (xfer_ch == CH_W'(g))),
            .cur_addr_o (cur_addr_a[g]),
            .cur_cnt_o  (cur_cnt_a[g]),
            .base_addr_o(base_addr_a[g]),
            .base_cnt_o (base_cnt_a[g]),
            .autoinit_o (auto_vec[g]),
            .tc_o       (tc_vec[g])
        );
    end

    dma_tc_track #(
        .NUM_CH(NUM_CH)
    ) i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_i       (tc_vec),
        .autoinit_i (auto_vec),
        .status_rd_i(status_rd),
        .mask_clr_i (mask_clr),
        .tc_status_o(tc_status),
        .mask_o     (req_mask)
    );

    assign xfer_addr    = cur_addr_a[xfer_ch];
    assign eop          = |tc_vec;
    assign rd_cur_addr  = cur_addr_a[rd_ch];
    assign rd_cur_cnt   = cur_cnt_a[rd_ch];
    assign rd_base_addr = base_addr_a[rd_ch];
    assign rd_base_cnt  = base_cnt_a[rd_ch];

    // R6
    eop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_vec));

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && req_mask[xfer_ch]) |-> !eop);
endmodule

// File: tb/test_dma_ac_engine.sv
module test_dma_ac_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 0, prog_sel = 0, mode_we = 0, mode_autoinit = 0, mode_down = 0;
    logic [1:0]  prog_ch = 0, mode_ch = 0, xfer_ch = 0, rd_ch = 0;
    logic [15:0] prog_data = 0;
    logic        xfer = 0, status_rd = 0;
    logic [3:0]  mask_clr = 0;
    logic [15:0] xfer_addr, rd_cur_addr, rd_cur_cnt, rd_base_addr, rd_base_cnt;
    logic        eop;
    logic [3:0]  tc_status, req_mask;

    int n_checks = 0, n_errs = 0;
    bit chk_en = 0, done = 0;

    int m_addr[4], m_cnt[4], m_baddr[4], m_bcnt[4];
    bit m_auto[4], m_down[4], m_tc[4], m_mask[4];

    always #4 clk = ~clk;

    dma_ac_engine i_dma_ac_engine (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_ch(prog_ch), .prog_sel(prog_sel), .prog_data(prog_data),
        .mode_we(mode_we), .mode_ch(mode_ch), .mode_autoinit(mode_autoinit), .mode_down(mode_down),
        .xfer(xfer), .xfer_ch(xfer_ch), .xfer_addr(xfer_addr), .eop(eop),
        .status_rd(status_rd), .tc_status(tc_status),
        .mask_clr(mask_clr), .req_mask(req_mask),
        .rd_ch(rd_ch), .rd_cur_addr(rd_cur_addr), .rd_cur_cnt(rd_cur_cnt),
        .rd_base_addr(rd_base_addr), .rd_base_cnt(rd_base_cnt)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit accepted();
        return xfer && !m_mask[xfer_ch] && !(prog_we && prog_ch == xfer_ch);
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_addr[c] = 0; m_cnt[c] = 0; m_baddr[c] = 0; m_bcnt[c] = 0;
                m_auto[c] = 0; m_down[c] = 0; m_tc[c] = 0; m_mask[c] = 1;
            end
        end else begin
            bit acc;
            bit last;
            int c;
            acc  = accepted();
            c    = xfer_ch;
            last = acc && (m_cnt[c] == 0);
            for (int k = 0; k < 4; k++) begin
                if (status_rd) m_tc[k] = 0;
                if (mask_clr[k]) m_mask[k] = 0;
            end
            if (last) begin
                m_tc[c] = 1;
                if (!m_auto[c]) m_mask[c] = 1;
            end
            if (acc) begin
                if (last && m_auto[c]) begin
                    m_addr[c] = m_baddr[c];
                    m_cnt[c]  = m_bcnt[c];
                end else begin
                    m_addr[c] = (m_addr[c] + (m_down[c] ? 65535 : 1)) % 65536;
                    m_cnt[c]  = (m_cnt[c] + 65535) % 65536;
                end
            end
            if (mode_we) begin
                m_auto[mode_ch] = mode_autoinit;
                m_down[mode_ch] = mode_down;
            end
            if (prog_we) begin
                if (prog_sel) begin m_cnt[prog_ch] = prog_data; m_bcnt[prog_ch] = prog_data; end
                else          begin m_addr[prog_ch] = prog_data; m_baddr[prog_ch] = prog_data; end
            end
        end
    end

    // the readback channel rotates every cycle
    always @(posedge clk) rd_ch <= rd_ch + 2'd1;

    // compare against the reference on every clock, away from the edge
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R3", "xfer_addr", xfer_addr, m_addr[xfer_ch]);
            chk("R6", "eop", eop, int'(accepted() && m_cnt[xfer_ch] == 0));
            for (int k = 0; k < 4; k++) begin
                chk("R7", "tc_status bit", tc_status[k], m_tc[k]);
                chk("R9", "req_mask bit", req_mask[k], m_mask[k]);
            end
            chk("R4", "rd_cur_addr", rd_cur_addr, m_addr[rd_ch]);
            chk("R5", "rd_cur_cnt", rd_cur_cnt, m_cnt[rd_ch]);
            chk("R2", "rd_base_addr", rd_base_addr, m_baddr[rd_ch]);
            chk("R8", "rd_base_cnt", rd_base_cnt, m_bcnt[rd_ch]);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        prog_we = 0; mode_we = 0; xfer = 0; status_rd = 0; mask_clr = 0;
    endtask

    task automatic prog(input int ch, input bit s, input int d);
        prog_we = 1; prog_ch = 2'(ch); prog_sel = s; prog_data = 16'(d);
        tick(); idle();
    endtask

    task automatic set_mode(input int ch, input bit ai, input bit dn);
        mode_we = 1; mode_ch = 2'(ch); mode_autoinit = ai; mode_down = dn;
        tick(); idle();
    endtask

    task automatic xf(input int ch);
        xfer = 1; xfer_ch = 2'(ch);
        tick(); idle();
    endtask

    task automatic peek(input int ch);
        do @(negedge clk); while (rd_ch != 2'(ch));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_en = 1;
        // R1: reset state at the ports
        @(negedge clk);
        chk("R1", "req_mask after reset", req_mask, 4'hF);
        chk("R1", "tc_status after reset", tc_status, 0);
        for (int c = 0; c < 4; c++) begin
            peek(c);
            chk("R1", "cur_addr after reset", rd_cur_addr, 0);
            chk("R1", "cur_cnt after reset", rd_cur_cnt, 0);
        end
        // R10: transfer on a masked channel does nothing
        @(posedge clk); #1;
        xf(3);
        peek(3);
        chk("R10", "masked cnt", rd_cur_cnt, 0);
        chk("R10", "masked addr", rd_cur_addr, 0);

        mask_clr = 4'hF; tick(); idle();

        // R2 and R4: channel 0, incrementing, 4 transfers
        prog(0, 0, 16'h1000);
        prog(0, 1, 3);
        peek(0);
        chk("R2", "base addr ch0", rd_base_addr, 16'h1000);
        chk("R2", "cur cnt ch0", rd_cur_cnt, 3);
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++) xf(0);
        peek(0);
        chk("R9", "ch0 masked after tc", req_mask[0], 1);
        chk("R6", "ch0 count after tc", rd_cur_cnt, 16'hFFFF);
        chk("R4", "ch0 addr after 4", rd_cur_addr, 16'h1004);
        @(posedge clk); #1;
        xf(0);
        peek(0);
        chk("R10", "ch0 masked addr held", rd_cur_addr, 16'h1004);

        // R8: channel 1, decrementing, auto-initialising, 2 transfers per run
        set_mode(1, 1, 1);
        prog(1, 0, 16'h0002);
        prog(1, 1, 1);
        xf(1); xf(1);
        peek(1);
        chk("R8", "ch1 addr reloaded", rd_cur_addr, 16'h0002);
        chk("R8", "ch1 cnt reloaded", rd_cur_cnt, 1);
        chk("R9", "ch1 not masked", req_mask[1], 0);
        @(posedge clk); #1;
        xf(1);
        status_rd = 1; xfer = 1; xfer_ch = 2'd1; tick(); idle();
        @(negedge clk);
        chk("R7", "tc set wins over read", tc_status[1], 1);
        status_rd = 1; tick(); idle();
        @(negedge clk);
        chk("R7", "cleared by read", tc_status, 0);

        // R4: address wrap on channel 2
        prog(2, 0, 16'hFFFF);
        prog(2, 1, 0);
        xf(2);
        peek(2);
        chk("R4", "ch2 wrap", rd_cur_addr, 16'h0000);

        // R11: write and transfer hit the same channel
        mask_clr = 4'h4; tick(); idle();
        prog(2, 1, 5);
        prog_we = 1; prog_ch = 2'd2; prog_sel = 0; prog_data = 16'h4444;
        xfer = 1; xfer_ch = 2'd2;
        tick(); idle();
        peek(2);
        chk("R11", "write wins addr", rd_cur_addr, 16'h4444);
        chk("R11", "transfer dropped cnt", rd_cur_cnt, 5);

        // R12: channel 3 untouched by all of the above
        peek(3);
        chk("R12", "ch3 addr", rd_cur_addr, 0);
        chk("R12", "ch3 cnt", rd_cur_cnt, 0);
        chk("R12", "ch3 tc", tc_status[3], 0);

        // mixed random traffic against the reference
        @(posedge clk); #1;
        for (int i = 0; i < 3000; i++) begin
            xfer    = ($urandom % 4) != 0;
            xfer_ch = 2'($urandom);
            prog_we = ($urandom % 10) == 0;
            prog_ch = 2'($urandom);
            prog_sel = 1'($urandom);
            prog_data = prog_sel ? 16'($urandom % 6) : 16'($urandom);
            mode_we = ($urandom % 20) == 0;
            mode_ch = 2'($urandom);
            mode_autoinit = 1'($urandom);
            mode_down = 1'($urandom);
            status_rd = ($urandom % 8) == 0;
            mask_clr = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            tick();
        end
        idle();
        repeat (4) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule